// File: doc/BRIEF.md
# Vector Length Auto-Sectioning Controller

This block keeps the vector configuration state of a vector unit: the remaining element count, the current section index and a flag that enables per-element masking. Software uses it to walk an array of any length in slices that match the hardware section size. It never needs that size at compile time, because dedicated step instructions advance the index by the section size and reduce the remaining length by it. The length is clamped at zero when the remaining count runs out.

Configuration instructions arrive on a single issue port together with up to three scalar operands and a destination register number. Instructions that produce a scalar result return it on a registered write-back port. Every cycle the block also gives the vector datapath the number of elements active in the current section: the smaller of the remaining length and the section size. A zero length therefore means that no element is processed.

Top module: `vsect_ctrl`

## Requirements
- R1: After reset, the length, index, mask flag and active count are 0, and no write-back is signalled.
- R2: Opcode 1 (set) loads the length from operand A and the index from operand B. It sets the mask flag to 1 when operand C is nonzero and to 0 otherwise. It produces no write-back.
- R3: Opcode 2 (index step) replaces the index with index + SECTION, modulo 2^XLEN, and writes the new index back.
- R4: Opcode 3 (length step) replaces the length with length − SECTION when length > SECTION, and with 0 otherwise. It never wraps, and it writes the new length back.
- R5: Opcode 4 sets the mask flag to 1 and opcode 5 clears it to 0. Neither produces a write-back.
- R6: Opcode 6 writes SECTION back and leaves length, index and mask unchanged.
- R7: active_cnt_o always equals min(length, SECTION), and it is 0 whenever the length is 0.
- R8: wb_valid_o is high in exactly the cycle after an accepted opcode 2, 3 or 6, and wb_dst_o repeats that instruction's destination.
- R9: Opcodes 0 and 7, and any cycle with issue_valid_i low, change no state and produce no write-back.
- R10: A step instruction issued in the cycle right after a set works on the values loaded by that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Instruction valid this cycle |
| issue_op_i | input | 3 | Opcode: 0 nop, 1 set, 2 index step, 3 length step, 4 mask on, 5 mask off, 6 section query, 7 reserved |
| opnd_a_i | input | XLEN | Scalar operand A (length for set) |
| opnd_b_i | input | XLEN | Scalar operand B (index for set) |
| opnd_c_i | input | XLEN | Scalar operand C (mask flag for set, nonzero means on) |
| dst_i | input | DST_W | Scalar destination register number |
| wb_valid_o | output | 1 | Write-back valid |
| wb_dst_o | output | DST_W | Write-back destination register |
| wb_data_o | output | XLEN | Write-back data |
| vlen_o | output | XLEN | Current remaining length |
| vidx_o | output | XLEN | Current section index |
| mask_en_o | output | 1 | Mask enable flag |
| active_cnt_o | output | CNT_W | Active elements in the current section |

## Verification
An instruction driven before a rising edge updates length, index and mask on that edge. The active count follows combinationally in the same cycle, and the write-back appears registered one cycle after issue. The bench drives on the falling edge and checks state, active count and write-back valid on the next falling edge, after exactly one rising edge. A queue holds each expected write-back result. A monitor pops one entry on every falling edge at which write-back valid is high, and it reports any result that is missing or was not expected.

// File: rtl/vsect_pkg.sv
package vsect_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_SET      = 3'd1,
    OP_STEP_IDX = 3'd2,
    OP_STEP_LEN = 3'd3,
    OP_MASK_ON  = 3'd4,
    OP_MASK_OFF = 3'd5,
    OP_GET_SS   = 3'd6,
    OP_RSVD     = 3'd7
  } vs_op_e;

  typedef struct packed {
    logic set;
    logic step_idx;
    logic step_len;
    logic mask_on;
    logic mask_off;
    logic get_ss;
  } vs_ctl_t;
endpackage

// File: rtl/vsect_decode.sv
module vsect_decode
  import vsect_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [2:0] op_i,
  output vs_ctl_t    ctl_o
);
  vs_op_e op;
  assign op = vs_op_e'(op_i);

  always_comb begin
    ctl_o = '0;
    if (valid_i) begin
      unique case (op)
        OP_SET:      ctl_o.set      = 1'b1;
        OP_STEP_IDX: ctl_o.step_idx = 1'b1;
        OP_STEP_LEN: ctl_o.step_len = 1'b1;
        OP_MASK_ON:  ctl_o.mask_on  = 1'b1;
        OP_MASK_OFF: ctl_o.mask_off = 1'b1;
        OP_GET_SS:   ctl_o.get_ss   = 1'b1;
        default:     ctl_o = '0;
      endcase
    end
  end

  // R9: reserved, nop and idle issue slots raise no control
  a_r9_idle_no_ctl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i == 3'd0 || op_i == 3'd7) |-> (ctl_o == '0));
endmodule

// File: rtl/vsect_step.sv
module vsect_step #(
  parameter int XLEN    = 32,
  parameter int SECTION = 64,
  parameter int CNT_W   = $clog2(SECTION + 1)
) (
  input  logic [XLEN-1:0]  vlen_i,
  input  logic [XLEN-1:0]  vidx_i,
  output logic [XLEN-1:0]  idx_next_o,
  output logic [XLEN-1:0]  len_next_o,
  output logic [CNT_W-1:0] active_o
);
  localparam logic [XLEN-1:0]  SS_X = XLEN'(SECTION);
  localparam logic [CNT_W-1:0] SS_C = CNT_W'(SECTION);

  logic more_than_ss;
  assign more_than_ss = (vlen_i > SS_X);

  assign idx_next_o = vidx_i + SS_X;
  // saturating subtract: compare first, never wrap
  assign len_next_o = more_than_ss ? (vlen_i - SS_X) : '0;
  assign active_o   = (vlen_i < SS_X) ? CNT_W'(vlen_i) : SS_C;
endmodule

// File: rtl/vsect_regs.sv
module vsect_regs
  import vsect_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  vs_ctl_t         ctl_i,
  input  logic [XLEN-1:0] opnd_a_i,
  input  logic [XLEN-1:0] opnd_b_i,
  input  logic [XLEN-1:0] opnd_c_i,
  input  logic [XLEN-1:0] idx_next_i,
  input  logic [XLEN-1:0] len_next_i,
  output logic [XLEN-1:0] vlen_o,
  output logic [XLEN-1:0] vidx_o,
  output logic            mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vlen_o <= '0;
      vidx_o <= '0;
      mask_o <= 1'b0;
    end else begin
      if (ctl_i.set) begin
        vlen_o <= opnd_a_i;
        vidx_o <= opnd_b_i;
        mask_o <= |opnd_c_i;
      end
      if (ctl_i.step_idx) vidx_o <= idx_next_i;
      if (ctl_i.step_len) vlen_o <= len_next_i;
      if (ctl_i.mask_on)  mask_o <= 1'b1;
      if (ctl_i.mask_off) mask_o <= 1'b0;
    end
  end

  a_r2_set_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.set |=> (vlen_o == $past(opnd_a_i) && vidx_o == $past(opnd_b_i)
                   && mask_o == ($past(opnd_c_i) != '0)));
  a_r4_len_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.step_len |=> (vlen_o <= $past(vlen_o)));
  a_r5_mask_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.mask_on |=> mask_o);
  a_r5_mask_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.mask_off |=> !mask_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i == '0 || ctl_i.get_ss) |=>
      ($stable(vlen_o) && $stable(vidx_o) && $stable(mask_o)));
endmodule

// File: rtl/vsect_wb.sv
module vsect_wb
  import vsect_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SECTION = 64,
  parameter int DST_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  vs_ctl_t          ctl_i,
  input  logic [DST_W-1:0] dst_i,
  input  logic [XLEN-1:0]  idx_next_i,
  input  logic [XLEN-1:0]  len_next_i,
  output logic             wb_valid_o,
  output logic [DST_W-1:0] wb_dst_o,
  output logic [XLEN-1:0]  wb_data_o
);
  logic            has_res;
  logic [XLEN-1:0] res;

  assign has_res = ctl_i.step_idx | ctl_i.step_len | ctl_i.get_ss;

  always_comb begin
    res = '0;
    if (ctl_i.step_idx)      res = idx_next_i;
    else if (ctl_i.step_len) res = len_next_i;
    else if (ctl_i.get_ss)   res = XLEN'(SECTION);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_dst_o   <= '0;
      wb_data_o  <= '0;
    end else begin
      wb_valid_o <= has_res;
      if (has_res) begin
        wb_dst_o  <= dst_i;
        wb_data_o <= res;
      end
    end
  end

  a_r8_wb_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(has_res));
  a_r8_wb_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    has_res |=> (wb_valid_o && wb_dst_o == $past(dst_i)));
  a_r6_ss_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.get_ss |=> (wb_data_o == XLEN'(SECTION)));
endmodule

// File: rtl/vsect_ctrl.sv
module vsect_ctrl
  import vsect_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SECTION = 64,
  parameter int DST_W   = 5,
  localparam int CNT_W  = $clog2(SECTION + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic [2:0]       issue_op_i,
  input  logic [XLEN-1:0]  opnd_a_i,
  input  logic [XLEN-1:0]  opnd_b_i,
  input  logic [XLEN-1:0]  opnd_c_i,
  input  logic [DST_W-1:0] dst_i,
  output logic             wb_valid_o,
  output logic [DST_W-1:0] wb_dst_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic [XLEN-1:0]  vlen_o,
  output logic [XLEN-1:0]  vidx_o,
  output logic             mask_en_o,
  output logic [CNT_W-1:0] active_cnt_o
);
  vs_ctl_t         ctl;
  logic [XLEN-1:0] idx_next;
  logic [XLEN-1:0] len_next;

  vsect_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (issue_valid_i),
    .op_i    (issue_op_i),
    .ctl_o   (ctl)
  );

  vsect_step #(.XLEN(XLEN), .SECTION(SECTION), .CNT_W(CNT_W)) u_step (
    .vlen_i     (vlen_o),
    .vidx_i     (vidx_o),
    .idx_next_o (idx_next),
    .len_next_o (len_next),
    .active_o   (active_cnt_o)
  );

  vsect_regs #(.XLEN(XLEN)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctl),
    .opnd_a_i   (opnd_a_i),
    .opnd_b_i   (opnd_b_i),
    .opnd_c_i   (opnd_c_i),
    .idx_next_i (idx_next),
    .len_next_i (len_next),
    .vlen_o     (vlen_o),
    .vidx_o     (vidx_o),
    .mask_o     (mask_en_o)
  );

  vsect_wb #(.XLEN(XLEN), .SECTION(SECTION), .DST_W(DST_W)) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctl),
    .dst_i      (dst_i),
    .idx_next_i (idx_next),
    .len_next_i (len_next),
    .wb_valid_o (wb_valid_o),
    .wb_dst_o   (wb_dst_o),
    .wb_data_o  (wb_data_o)
  );

  a_r7_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vlen_o == '0) |-> (active_cnt_o == '0));
  a_r7_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_cnt_o <= CNT_W'(SECTION));
  a_r3_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.step_idx |=> (vidx_o == $past(vidx_o) + XLEN'(SECTION)));
endmodule

// File: tb/vsect_ctrl_tb_top.sv
module vsect_ctrl_tb_top;
  localparam int XLEN  = 32;
  localparam int SS    = 64;
  localparam int DST_W = 5;
  localparam int CNT_W = $clog2(SS + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             issue_valid_i = 1'b0;
  logic [2:0]       issue_op_i = '0;
  logic [XLEN-1:0]  opnd_a_i = '0, opnd_b_i = '0, opnd_c_i = '0;
  logic [DST_W-1:0] dst_i = '0;
  logic             wb_valid_o;
  logic [DST_W-1:0] wb_dst_o;
  logic [XLEN-1:0]  wb_data_o, vlen_o, vidx_o;
  logic             mask_en_o;
  logic [CNT_W-1:0] active_cnt_o;

  always #10 clk_i = ~clk_i;

  vsect_ctrl #(.XLEN(XLEN), .SECTION(SS), .DST_W(DST_W)) dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [XLEN-1:0]  m_len = '0, m_idx = '0;
  logic             m_mask = 1'b0;
  logic [XLEN-1:0]  q_data[$];
  logic [DST_W-1:0] q_dst[$];
  string            q_req[$];

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] m_active();
    return (m_len < XLEN'(SS)) ? m_len : XLEN'(SS);
  endfunction

  // driver: called at a falling edge, returns at the next falling edge
  task automatic issue(input logic v, input logic [2:0] op, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] b, input logic [XLEN-1:0] c,
                       input logic [DST_W-1:0] d, input string req);
    bit exp_wb = 0;
    issue_valid_i = v; issue_op_i = op;
    opnd_a_i = a; opnd_b_i = b; opnd_c_i = c; dst_i = d;
    if (v) begin
      case (op)
        3'd1: begin m_len = a; m_idx = b; m_mask = (c != '0); end
        3'd2: begin
          m_idx = m_idx + XLEN'(SS);
          exp_wb = 1; q_data.push_back(m_idx); q_dst.push_back(d); q_req.push_back("R3");
        end
        3'd3: begin
          m_len = (m_len > XLEN'(SS)) ? m_len - XLEN'(SS) : '0;
          exp_wb = 1; q_data.push_back(m_len); q_dst.push_back(d); q_req.push_back("R4");
        end
        3'd4: m_mask = 1'b1;
        3'd5: m_mask = 1'b0;
        3'd6: begin
          exp_wb = 1; q_data.push_back(XLEN'(SS)); q_dst.push_back(d); q_req.push_back("R6");
        end
        default: ;
      endcase
    end
    @(negedge clk_i);
    issue_valid_i = 1'b0;
    chk(vlen_o == m_len, {req, " len"}, vlen_o, m_len);
    chk(vidx_o == m_idx, {req, " idx"}, vidx_o, m_idx);
    chk(mask_en_o == m_mask, {req, " mask"}, XLEN'(mask_en_o), XLEN'(m_mask));
    chk(XLEN'(active_cnt_o) == m_active(), "R7 active", XLEN'(active_cnt_o), m_active());
    chk(wb_valid_o == exp_wb, {"R8 wb_valid after ", req}, XLEN'(wb_valid_o), XLEN'(exp_wb));
  endtask

  // monitor: scoreboard pop on every write-back
  always @(negedge clk_i) begin
    if (rst_ni && wb_valid_o) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R8 unexpected wb", wb_data_o, '0);
      end else begin
        logic [XLEN-1:0]  ed;
        logic [DST_W-1:0] edst;
        string            er;
        ed = q_data.pop_front(); edst = q_dst.pop_front(); er = q_req.pop_front();
        chk(wb_data_o == ed, {er, " wb data"}, wb_data_o, ed);
        chk(wb_dst_o == edst, "R8 wb dst", XLEN'(wb_dst_o), XLEN'(edst));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(vlen_o == '0, "R1 len", vlen_o, '0);
    chk(vidx_o == '0, "R1 idx", vidx_o, '0);
    chk(mask_en_o == 1'b0, "R1 mask", XLEN'(mask_en_o), '0);
    chk(active_cnt_o == '0, "R1 active", XLEN'(active_cnt_o), '0);
    chk(wb_valid_o == 1'b0, "R1 wb", XLEN'(wb_valid_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    issue(1, 3'd1, 130, 0, 1, 0, "R2");
    issue(1, 3'd2, 0, 0, 0, 3, "R10");   // step right after set
    issue(1, 3'd3, 0, 0, 0, 4, "R4");    // 130 -> 66
    issue(1, 3'd3, 0, 0, 0, 4, "R4");    // 66 -> 2
    issue(1, 3'd3, 0, 0, 0, 9, "R4");    // 2 -> 0
    issue(1, 3'd3, 0, 0, 0, 9, "R4");    // stays 0
    issue(1, 3'd6, 5, 6, 7, 7, "R6");
    issue(1, 3'd5, 0, 0, 0, 0, "R5");
    issue(1, 3'd4, 0, 0, 0, 0, "R5");
    issue(1, 3'd0, 11, 12, 0, 1, "R9");
    issue(1, 3'd7, 11, 12, 0, 1, "R9");
    issue(0, 3'd1, 11, 12, 0, 1, "R9");
    issue(0, 3'd2, 0, 0, 0, 2, "R9");
    issue(1, 3'd1, 64, 32'hFFFF_FFF0, 0, 0, "R2");
    issue(1, 3'd3, 0, 0, 0, 5, "R10");   // exactly SS -> 0
    issue(1, 3'd2, 0, 0, 0, 6, "R3");    // index wraps
    issue(1, 3'd1, 65, 7, 2, 0, "R2");   // nonzero C sets mask
    issue(1, 3'd3, 0, 0, 0, 8, "R4");    // 65 -> 1
    issue(1, 3'd6, 0, 0, 0, 31, "R6");
    issue(1, 3'd1, 0, 0, 0, 0, "R2");    // zero length
    issue(0, 3'd0, 0, 0, 0, 0, "R9");
    chk(q_data.size() == 0, "R8 all results seen", XLEN'(q_data.size()), '0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule